// File: doc/BRIEF.md
# Single-Step Multiply, Divide and CRC Datapath

This unit is a 16-bit arithmetic slice for a stack-oriented processor. It executes one iteration of a long operation per clock: a shift-and-add multiply step, the two halves of a restoring divide step, or one bit of a CRC. A working register W and a carry flag CF live inside the unit. Each instruction pairs W with an operand B, and some also use an operand A. Helper operations open and close a multiply, load W, and move bits through W and CF with rotates and word shifts.

The unit does no sequencing of its own. The surrounding core (a repeat counter, for example) issues the step opcode once per iteration. It supplies A and B from its register file each cycle and writes back the updated operand values the unit returns. The operand outputs are combinational from the current inputs, W and CF. W and CF update on the next rising clock edge.

Top module: `wstep_dp`

## Requirements
- R1: While rst_ni is low, W and CF are zero.
- R2: Opcode 1 (load) sets W to B and clears CF at the next edge.
- R3: Opcode 3 (multiply step) forms ({W,B} shifted left by one) plus A when W bit 15 is set, as a 32-bit value. It returns the low half on b_o, loads the high half into W and leaves CF unchanged. Sixteen steps from W=x, B=0, A=y leave {W,B}=x*y.
- R4: Opcode 2 (multiply begin) sets W to B shifted right by one and clears CF.
- R5: Opcode 4 (multiply end) sets W to ((W+CF) shifted left by one) with bit 0 taken from B bit 15, truncated to 16 bits, and clears CF.
- R6: Opcode 5 (divide step 1) forms A+B. If it carries out of bit 15, the 16-bit sum is returned on a_o; otherwise A is returned unchanged. The carry is latched into CF, and the a_o value is also loaded into W.
- R7: Opcode 6 (divide step 2) shifts {W,B} left by one with CF entering bit 0. It returns the low half on b_o, loads the high half into W and leaves CF unchanged.
- R8: Opcode 7 (CRC step) returns B shifted left by one, XORed with A when W bit 15 is set, on b_o. It also loads that value into W and leaves CF unchanged.
- R9: Opcode 8 (rotate left through carry) returns {B[14:0],CF}. Opcode 9 (rotate right through carry) returns {CF,B[15:1]}. Both put the result on a_o and in W, and load the bit shifted out into CF.
- R10: Opcode 10 (word shift left) returns {B[14:0],W[15]}. Opcode 11 (word shift right) returns {W[15],B[15:1]}. Both put the result on a_o and in W and leave CF unchanged.
- R11: Opcode 0 and the unused opcodes 12 to 15 hold W and CF, and pass A and B through unchanged to a_o and b_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 4 | Step opcode |
| a_i | input | 16 | A operand |
| b_i | input | 16 | B operand |
| a_o | output | 16 | Updated A operand |
| b_o | output | 16 | Updated B operand |
| w_o | output | 16 | Working register W |
| cf_o | output | 1 | Carry flag |

## Verification
The checker runs on every cycle and covers the per-opcode register effects:
- CF is cleared by load and the multiply helpers.
- CF is preserved across multiply, divide-2, CRC and word-shift steps.
- The rotated-out bit lands in CF.
- The divide-1, CRC and shift results reach W one edge after they appear on the operand outputs.
- NOP holds W and CF, and passes the operands through.

Only the bench scenarios can show that chained steps compute the right arithmetic. These are 16 multiply steps yielding a 32-bit product, and 16 divide step pairs yielding the quotient and remainder. The bench also checks the exact carry-dependent values of the helpers and the polynomial selection of the CRC step.

// File: rtl/wstep_pkg.sv
package wstep_pkg;
  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_LDW   = 4'd1,
    OP_MBEG  = 4'd2,
    OP_MSTEP = 4'd3,
    OP_MEND  = 4'd4,
    OP_DIV1  = 4'd5,
    OP_DIV2  = 4'd6,
    OP_CRC   = 4'd7,
    OP_ROLC  = 4'd8,
    OP_RORC  = 4'd9,
    OP_WSL   = 4'd10,
    OP_WSR   = 4'd11
  } step_op_e;
endpackage

// File: rtl/wstep_mul.sv
module wstep_mul #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] w_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cf_i,
  output logic [WIDTH-1:0] step_w_o,
  output logic [WIDTH-1:0] step_b_o,
  output logic [WIDTH-1:0] beg_w_o,
  output logic [WIDTH-1:0] end_w_o
);
  localparam int unsigned PW = 2 * WIDTH;

  logic [PW-1:0]    pair_sh;
  logic [PW-1:0]    pair_sum;
  logic [WIDTH-1:0] w_plus_cf;

  always_comb begin
    pair_sh  = {w_i, b_i} << 1;
    pair_sum = pair_sh + (w_i[WIDTH-1] ? {{WIDTH{1'b0}}, a_i} : '0);
    step_w_o = pair_sum[PW-1:WIDTH];
    step_b_o = pair_sum[WIDTH-1:0];
    beg_w_o  = b_i >> 1;
    w_plus_cf = w_i + {{(WIDTH-1){1'b0}}, cf_i};
    end_w_o  = (w_plus_cf << 1) | {{(WIDTH-1){1'b0}}, b_i[WIDTH-1]};
  end
endmodule

// File: rtl/wstep_div.sv
module wstep_div #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] w_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cf_i,
  output logic [WIDTH-1:0] d1_a_o,
  output logic             d1_cf_o,
  output logic [WIDTH-1:0] d2_w_o,
  output logic [WIDTH-1:0] d2_b_o
);
  localparam int unsigned PW = 2 * WIDTH;

  logic [WIDTH:0] trial;
  logic [PW-1:0]  pair_sh;

  always_comb begin
    trial   = {1'b0, a_i} + {1'b0, b_i};
    d1_cf_o = trial[WIDTH];
    d1_a_o  = trial[WIDTH] ? trial[WIDTH-1:0] : a_i;
    pair_sh = ({w_i, b_i} << 1) | {{(PW-1){1'b0}}, cf_i};
    d2_w_o  = pair_sh[PW-1:WIDTH];
    d2_b_o  = pair_sh[WIDTH-1:0];
  end
endmodule

// File: rtl/wstep_shift.sv
module wstep_shift #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             w_msb_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cf_i,
  output logic [WIDTH-1:0] crc_o,
  output logic [WIDTH-1:0] rolc_o,
  output logic             rolc_cf_o,
  output logic [WIDTH-1:0] rorc_o,
  output logic             rorc_cf_o,
  output logic [WIDTH-1:0] wsl_o,
  output logic [WIDTH-1:0] wsr_o
);
  localparam logic [WIDTH-1:0] LSB_ONE = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] MSB_ONE = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] b_shl;
  logic [WIDTH-1:0] b_shr;

  always_comb begin
    b_shl     = b_i << 1;
    b_shr     = b_i >> 1;
    crc_o     = w_msb_i ? (b_shl ^ a_i) : b_shl;
    rolc_o    = b_shl | (cf_i ? LSB_ONE : '0);
    rolc_cf_o = b_i[WIDTH-1];
    rorc_o    = b_shr | (cf_i ? MSB_ONE : '0);
    rorc_cf_o = b_i[0];
    wsl_o     = b_shl | (w_msb_i ? LSB_ONE : '0);
    wsr_o     = b_shr | (w_msb_i ? MSB_ONE : '0);
  end
endmodule

// File: rtl/wstep_dp.sv
module wstep_dp
  import wstep_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] a_o,
  output logic [WIDTH-1:0] b_o,
  output logic [WIDTH-1:0] w_o,
  output logic             cf_o
);
  step_op_e         op;
  logic [WIDTH-1:0] w_q, w_d;
  logic             cf_q, cf_d;

  logic [WIDTH-1:0] m_step_w, m_step_b, m_beg_w, m_end_w;
  logic [WIDTH-1:0] d1_a, d2_w, d2_b;
  logic             d1_cf;
  logic [WIDTH-1:0] crc_r, rolc_r, rorc_r, wsl_r, wsr_r;
  logic             rolc_cf, rorc_cf;

  assign op = step_op_e'(op_i);

  wstep_mul #(.WIDTH(WIDTH)) u_mul (
    .w_i(w_q), .a_i(a_i), .b_i(b_i), .cf_i(cf_q),
    .step_w_o(m_step_w), .step_b_o(m_step_b),
    .beg_w_o(m_beg_w), .end_w_o(m_end_w)
  );

  wstep_div #(.WIDTH(WIDTH)) u_div (
    .w_i(w_q), .a_i(a_i), .b_i(b_i), .cf_i(cf_q),
    .d1_a_o(d1_a), .d1_cf_o(d1_cf), .d2_w_o(d2_w), .d2_b_o(d2_b)
  );

  wstep_shift #(.WIDTH(WIDTH)) u_shift (
    .w_msb_i(w_q[WIDTH-1]), .a_i(a_i), .b_i(b_i), .cf_i(cf_q),
    .crc_o(crc_r), .rolc_o(rolc_r), .rolc_cf_o(rolc_cf),
    .rorc_o(rorc_r), .rorc_cf_o(rorc_cf), .wsl_o(wsl_r), .wsr_o(wsr_r)
  );

  always_comb begin
    w_d  = w_q;
    cf_d = cf_q;
    a_o  = a_i;
    b_o  = b_i;
    unique case (op)
      OP_LDW:   begin w_d = b_i; cf_d = 1'b0; end
      OP_MBEG:  begin w_d = m_beg_w; cf_d = 1'b0; end
      OP_MSTEP: begin w_d = m_step_w; b_o = m_step_b; end
      OP_MEND:  begin w_d = m_end_w; cf_d = 1'b0; end
      OP_DIV1:  begin a_o = d1_a; w_d = d1_a; cf_d = d1_cf; end
      OP_DIV2:  begin w_d = d2_w; b_o = d2_b; end
      OP_CRC:   begin b_o = crc_r; w_d = crc_r; end
      OP_ROLC:  begin a_o = rolc_r; w_d = rolc_r; cf_d = rolc_cf; end
      OP_RORC:  begin a_o = rorc_r; w_d = rorc_r; cf_d = rorc_cf; end
      OP_WSL:   begin a_o = wsl_r; w_d = wsl_r; end
      OP_WSR:   begin a_o = wsr_r; w_d = wsr_r; end
      default:  ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_q  <= '0;
      cf_q <= 1'b0;
    end else begin
      w_q  <= w_d;
      cf_q <= cf_d;
    end
  end

  assign w_o  = w_q;
  assign cf_o = cf_q;
endmodule

// File: rtl/wstep_dp_chk.sv
module wstep_dp_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [3:0]       op_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [WIDTH-1:0] a_o,
  input logic [WIDTH-1:0] b_o,
  input logic [WIDTH-1:0] w_o,
  input logic             cf_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_r1: assert (w_o == '0 && !cf_o);
    end
  end

  p_ldw_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 4'd1 |=> (w_o == $past(b_i) && !cf_o));

  p_mstep_cf_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 4'd3 |=> cf_o == $past(cf_o));

  p_mbeg_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 4'd2 |=> (!cf_o && w_o == ($past(b_i) >> 1)));

  p_mend_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 4'd4 |=> (!cf_o && w_o[0] == $past(b_i[WIDTH-1])));

  p_div1_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 4'd5 |=> w_o == $past(a_o));

  p_div2_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 4'd6 |=> (cf_o == $past(cf_o) && w_o[0] == $past(b_i[WIDTH-1])));

  p_crc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 4'd7 |=> (w_o == $past(b_o) && cf_o == $past(cf_o)));

  p_rolc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 4'd8 |=> (cf_o == $past(b_i[WIDTH-1]) && w_o == $past(a_o)));

  p_rorc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 4'd9 |=> (cf_o == $past(b_i[0]) && w_o == $past(a_o)));

  p_wshift_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd10 || op_i == 4'd11) |=> (cf_o == $past(cf_o) && w_o == $past(a_o)));

  p_nop_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd0 || op_i >= 4'd12) |=> ($stable(w_o) && $stable(cf_o)));

  p_nop_pass_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd0 || op_i >= 4'd12) |-> (a_o == a_i && b_o == b_i));
endmodule

bind wstep_dp wstep_dp_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .a_i(a_i), .b_i(b_i),
  .a_o(a_o), .b_o(b_o), .w_o(w_o), .cf_o(cf_o)
);

// File: tb/tb_wstep_dp.sv
`timescale 1ns/1ps
module tb_wstep_dp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [15:0] a = '0, b = '0;
  logic [15:0] a_o, b_o, w_o;
  logic        cf_o;
  logic [15:0] cap_a, cap_b;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  wstep_dp dut (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .a_i(a), .b_i(b),
    .a_o(a_o), .b_o(b_o), .w_o(w_o), .cf_o(cf_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive at negedge, capture comb outputs, let W/CF update, return to NOP
  task automatic step(input logic [3:0] o, input logic [15:0] av, input logic [15:0] bv);
    @(negedge clk);
    op = o; a = av; b = bv;
    #1;
    cap_a = a_o; cap_b = b_o;
    @(posedge clk);
    #1;
    op = 4'd0;
  endtask

  task automatic t_reset;
    #1;
    check("R1 w", {16'h0, w_o}, 32'h0);
    check("R1 cf", {31'h0, cf_o}, 32'h0);
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic t_load_nop;
    step(4'd1, 16'h0, 16'h1357);
    check("R2 w", {16'h0, w_o}, 32'h1357);
    check("R2 cf", {31'h0, cf_o}, 32'h0);
    step(4'd0, 16'hAAAA, 16'h5555);
    check("R11 a_o", {16'h0, cap_a}, 32'hAAAA);
    check("R11 b_o", {16'h0, cap_b}, 32'h5555);
    check("R11 w", {16'h0, w_o}, 32'h1357);
    step(4'd15, 16'h1111, 16'h2222);
    check("R11 unused op w", {16'h0, w_o}, 32'h1357);
    check("R11 unused op b_o", {16'h0, cap_b}, 32'h2222);
  endtask

  task automatic t_mul(input logic [15:0] x, input logic [15:0] y);
    logic [15:0] bcur;
    step(4'd1, 16'h0, x);
    bcur = 16'h0;
    for (int i = 0; i < 16; i++) begin
      step(4'd3, y, bcur);
      bcur = cap_b;
    end
    check("R3 product", {w_o, bcur}, 32'(x) * 32'(y));
    check("R3 cf kept", {31'h0, cf_o}, 32'h0);
  endtask

  task automatic t_mul_helpers;
    step(4'd2, 16'h0, 16'h8003);
    check("R4 w", {16'h0, w_o}, 32'h4001);
    check("R4 cf", {31'h0, cf_o}, 32'h0);
    step(4'd5, 16'hFFFF, 16'h0002);   // produces W=1, CF=1
    check("R6 carry a_o", {16'h0, cap_a}, 32'h0001);
    check("R6 carry cf", {31'h0, cf_o}, 32'h1);
    check("R6 carry w", {16'h0, w_o}, 32'h0001);
    step(4'd4, 16'h0, 16'h8000);
    check("R5 with cf w", {16'h0, w_o}, 32'h0005);
    check("R5 cf cleared", {31'h0, cf_o}, 32'h0);
    step(4'd1, 16'h0, 16'h7FFF);
    step(4'd4, 16'h0, 16'h0000);
    check("R5 no cf w", {16'h0, w_o}, 32'hFFFE);
    step(4'd5, 16'h1234, 16'h0100);
    check("R6 no carry a_o", {16'h0, cap_a}, 32'h1234);
    check("R6 no carry cf", {31'h0, cf_o}, 32'h0);
  endtask

  task automatic t_div(input logic [15:0] n, input logic [15:0] d);
    logic [15:0] q, rem;
    step(4'd1, 16'h0, 16'h0);
    q = n;
    for (int i = 0; i < 16; i++) begin
      step(4'd6, 16'h0, q);
      q = cap_b;
      step(4'd5, w_o, 16'(-d));
    end
    rem = w_o;
    step(4'd6, 16'h0, q);
    q = cap_b;
    check("R7 quotient", {16'h0, q}, {16'h0, n / d});
    check("R6 remainder", {16'h0, rem}, {16'h0, n % d});
  endtask

  task automatic t_crc;
    step(4'd1, 16'h0, 16'h8000);
    step(4'd7, 16'h1021, 16'hC001);
    check("R8 poly b_o", {16'h0, cap_b}, 32'h9023);
    check("R8 poly w", {16'h0, w_o}, 32'h9023);
    step(4'd1, 16'h0, 16'h1234);
    step(4'd7, 16'h1021, 16'hC001);
    check("R8 plain b_o", {16'h0, cap_b}, 32'h8002);
    check("R8 cf", {31'h0, cf_o}, 32'h0);
  endtask

  task automatic t_rot;
    step(4'd1, 16'h0, 16'h0);
    step(4'd8, 16'h0, 16'h8001);
    check("R9 rolc a_o", {16'h0, cap_a}, 32'h0002);
    check("R9 rolc cf", {31'h0, cf_o}, 32'h1);
    step(4'd8, 16'h0, 16'h0001);
    check("R9 rolc in w", {16'h0, w_o}, 32'h0003);
    check("R9 rolc cf0", {31'h0, cf_o}, 32'h0);
    step(4'd8, 16'h0, 16'h8000);
    step(4'd9, 16'h0, 16'h0003);
    check("R9 rorc a_o", {16'h0, cap_a}, 32'h8001);
    check("R9 rorc cf", {31'h0, cf_o}, 32'h1);
    step(4'd9, 16'h0, 16'h0002);
    check("R9 rorc w", {16'h0, w_o}, 32'h8001);
    check("R9 rorc cf0", {31'h0, cf_o}, 32'h0);
  endtask

  task automatic t_wshift;
    step(4'd1, 16'h0, 16'h8000);
    step(4'd10, 16'h0, 16'h4000);
    check("R10 wsl a_o", {16'h0, cap_a}, 32'h8001);
    step(4'd10, 16'h0, 16'h0001);
    check("R10 wsl w", {16'h0, w_o}, 32'h0003);
    step(4'd1, 16'h0, 16'h8001);
    step(4'd11, 16'h0, 16'h0004);
    check("R10 wsr a_o", {16'h0, cap_a}, 32'h8002);
    step(4'd11, 16'h0, 16'h0100);
    check("R10 wsr w", {16'h0, w_o}, 32'h8080);
    check("R10 cf", {31'h0, cf_o}, 32'h0);
  endtask

  initial begin
    t_reset();
    t_load_nop();
    t_mul(16'hFFFF, 16'hFFFF);
    t_mul(16'h0000, 16'h1234);
    t_mul(16'h8001, 16'h0003);
    for (int k = 0; k < 6; k++) t_mul(16'($urandom), 16'($urandom));
    t_mul_helpers();
    t_div(16'hFFFF, 16'h0001);
    t_div(16'h0005, 16'h7FFF);
    t_div(16'd1000, 16'd7);
    for (int k = 0; k < 6; k++) t_div(16'($urandom), 16'($urandom_range(1, 32767)));
    t_crc();
    t_rot();
    t_wshift();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule